// File: doc/BRIEF.md
# Region Address Decoder with Wait States

This block routes each access from one bus master to one of a fixed number of memory-mapped regions. Every region has a naturally aligned, power-of-two window. It is programmed through a configuration port with a base address, a size, a read wait-state count, a write wait-state count, a valid flag and an optional priority flag. For each request the block checks size alignment first and then looks the address up among the regions. It either selects one region and passes it the offset inside its window, or it answers with an error code.

At most one region can carry the priority flag. That region is tested ahead of all others, wins wherever windows overlap, and matches whether or not its valid flag is set. Every other region takes part in the lookup only while its valid flag is set. A separate port sets or clears that flag at run time and leaves the window untouched. Among several matching ordinary regions, the lowest index wins.

The master raises `m_req` and holds its request fields until `m_rdy` pulses for one cycle. That cycle also carries the response code, the read data of the selected region and the target strobes. A successful access is stalled by the programmed wait states of the chosen region. An error completes in the cycle after acceptance.

Top module: `region_decoder`

## Requirements
- R1: An address hits a region when it lies in the window [base, base+size). The offset driven on `tgt_off` during the ready cycle is the address ANDed with (size-1).
- R2: A programmed size is rounded up to the next power of two. The programmed base is aligned down to that size. For example, base 0x2003 with size 5 gives the window 0x2000..0x2007.
- R3: Writing a region with `cfg_mc`=1 makes it the single priority region and removes the flag from any earlier holder. Rewriting the holder with `cfg_mc`=0 clears the flag. The priority region is checked first, wins any overlap and matches even while its valid flag is clear.
- R4: An ordinary region matches only while its valid flag is set. `vld_we` changes only that flag, so re-enabling a region restores its previous window.
- R5: When several valid ordinary regions match and no priority region matches, the region with the lowest index is selected.
- R6: An access that hits no region completes with `m_resp`=2 (bus error), with `tgt_sel`=0 and `m_rdata`=0.
- R7: `m_size` encodes 0=byte, 1=halfword, 2 or 3=word. A word with either of address bits 1:0 set, or a halfword with bit 0 set, completes with `m_resp`=1 (alignment error) and selects no region. This holds even when the address is unmapped. Byte accesses are never misaligned.
- R8: A successful read raises `m_rdy` in the cycle that lies (read wait states + 1) cycles after the accepting clock edge's request cycle. A successful write does the same with the write wait states. Error responses arrive after exactly 1 cycle.
- R9: `m_rdy` lasts one cycle. `tgt_sel` is one-hot with the selected region's index only in a ready cycle with `m_resp`=0. `m_rdata` returns that region's slice of `rg_rdata` (region i at bits i*DW) for a successful read and is 0 otherwise. A new request is accepted only after the previous one completes.
- R10: During and after reset, `m_rdy` is 0, no region is valid and no priority region exists, so any access gets a bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one region's full configuration |
| cfg_idx | input | IW | Region index for configuration write |
| cfg_base | input | AW | Region base address (aligned down by the block) |
| cfg_size | input | AW | Region size in bytes, 1 or more, rounded up to a power of two |
| cfg_rdly | input | CW | Read wait states |
| cfg_wdly | input | CW | Write wait states |
| cfg_valid | input | 1 | Valid flag loaded with the configuration |
| cfg_mc | input | 1 | Make this region the priority region |
| vld_we | input | 1 | Update one region's valid flag only |
| vld_idx | input | IW | Region index for valid update |
| vld_val | input | 1 | New valid flag value |
| m_req | input | 1 | Master request, held until `m_rdy` |
| m_we | input | 1 | 1 = write, 0 = read |
| m_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| m_addr | input | AW | Access address |
| m_rdy | output | 1 | One-cycle completion pulse |
| m_resp | output | 2 | 0 ok, 1 alignment error, 2 bus error (valid with `m_rdy`) |
| m_rdata | output | DW | Read data from the selected region |
| rg_rdata | input | NREG*DW | Read data of all regions, region i at bits i*DW |
| tgt_sel | output | NREG | One-hot region select in the completing cycle |
| tgt_off | output | AW | Offset inside the selected window |
| tgt_we | output | 1 | Write strobe to the selected region |

## Verification
The assertions hold on every cycle for the handshake shape: a ready pulse never lasts two cycles, and a target select appears only inside a successful ready cycle and is never more than one-hot. They also check that an error response never selects a region, and that a misaligned request always returns the alignment code on the very next cycle, whatever its address maps to. Only the bench scenarios can show which region wins under overlap, priority and valid changes. The same holds for offsets after size rounding, for the exact wait-state latency of reads against writes, and for the window that comes back when a region is re-enabled.

// File: rtl/region_decoder.sv
module region_decoder #(
  parameter int NREG = 4,
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int CW   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [$clog2(NREG)-1:0] cfg_idx,
  input  logic [AW-1:0]       cfg_base,
  input  logic [AW-1:0]       cfg_size,
  input  logic [CW-1:0]       cfg_rdly,
  input  logic [CW-1:0]       cfg_wdly,
  input  logic                cfg_valid,
  input  logic                cfg_mc,
  input  logic                vld_we,
  input  logic [$clog2(NREG)-1:0] vld_idx,
  input  logic                vld_val,
  input  logic                m_req,
  input  logic                m_we,
  input  logic [1:0]          m_size,
  input  logic [AW-1:0]       m_addr,
  output logic                m_rdy,
  output logic [1:0]          m_resp,
  output logic [DW-1:0]       m_rdata,
  input  logic [NREG*DW-1:0]  rg_rdata,
  output logic [NREG-1:0]     tgt_sel,
  output logic [AW-1:0]       tgt_off,
  output logic                tgt_we
);
  localparam int IW = $clog2(NREG);
  localparam logic [1:0] RESP_OK    = 2'd0;
  localparam logic [1:0] RESP_ALIGN = 2'd1;
  localparam logic [1:0] RESP_BUS   = 2'd2;

  function automatic logic [AW-1:0] span(input logic [AW-1:0] s);
    logic [AW-1:0] x;
    x = s - 1'b1;
    for (int k = 1; k < AW; k = k * 2) x = x | (x >> k);
    return x;
  endfunction

  logic [AW-1:0] base_q [NREG];
  logic [AW-1:0] mask_q [NREG];
  logic [CW-1:0] rdly_q [NREG];
  logic [CW-1:0] wdly_q [NREG];
  logic [NREG-1:0] valid_q;
  logic          mc_en;
  logic [IW-1:0] mc_idx;

  logic [AW-1:0] new_mask;
  assign new_mask = ~span(cfg_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '1;
        rdly_q[i] <= '0;
        wdly_q[i] <= '0;
      end
      valid_q <= '0;
      mc_en   <= 1'b0;
      mc_idx  <= '0;
    end else begin
      if (cfg_we) begin
        base_q[cfg_idx]  <= cfg_base & new_mask;
        mask_q[cfg_idx]  <= new_mask;
        rdly_q[cfg_idx]  <= cfg_rdly;
        wdly_q[cfg_idx]  <= cfg_wdly;
        valid_q[cfg_idx] <= cfg_valid;
        if (cfg_mc) begin
          mc_en  <= 1'b1;
          mc_idx <= cfg_idx;
        end else if (mc_en && mc_idx == cfg_idx) begin
          mc_en <= 1'b0;
        end
      end
      if (vld_we) valid_q[vld_idx] <= vld_val;
    end
  end

  logic          misal, hit;
  logic [IW-1:0] hidx;
  logic [CW-1:0] dly;

  assign misal = (m_size[1] && |m_addr[1:0]) || (m_size == 2'd1 && m_addr[0]);

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (valid_q[i] && ((m_addr & mask_q[i]) == base_q[i])) begin
        hit  = 1'b1;
        hidx = IW'(i);
      end
    end
    if (mc_en && ((m_addr & mask_q[mc_idx]) == base_q[mc_idx])) begin
      hit  = 1'b1;
      hidx = mc_idx;
    end
    dly = m_we ? wdly_q[hidx] : rdly_q[hidx];
  end

  logic          busy, we_q;
  logic [CW-1:0] cnt;
  logic [IW-1:0] sel_idx;
  logic [AW-1:0] off_q;
  logic [1:0]    resp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      we_q    <= 1'b0;
      cnt     <= '0;
      sel_idx <= '0;
      off_q   <= '0;
      resp_q  <= RESP_OK;
    end else if (!busy) begin
      if (m_req) begin
        busy    <= 1'b1;
        we_q    <= m_we;
        sel_idx <= hidx;
        off_q   <= m_addr & ~mask_q[hidx];
        resp_q  <= misal ? RESP_ALIGN : (hit ? RESP_OK : RESP_BUS);
        cnt     <= (!misal && hit) ? dly : '0;
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  logic ok;
  assign m_rdy   = busy && (cnt == '0);
  assign ok      = m_rdy && (resp_q == RESP_OK);
  assign m_resp  = m_rdy ? resp_q : RESP_OK;
  assign tgt_sel = ok ? (NREG'(1) << sel_idx) : '0;
  assign tgt_off = ok ? off_q : '0;
  assign tgt_we  = ok && we_q;
  assign m_rdata = (ok && !we_q) ? rg_rdata[sel_idx*DW +: DW] : '0;
endmodule

// File: rtl/region_decoder_chk.sv
module region_decoder_chk #(
  parameter int NREG = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic [1:0]      size,
  input logic [1:0]      addr_lo,
  input logic            rdy,
  input logic [1:0]      resp,
  input logic [NREG-1:0] sel,
  input logic            busy
);
  logic bad_align;
  assign bad_align = (size[1] && |addr_lo) || (size == 2'd1 && addr_lo[0]);

  a_r9_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);

  a_r9_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  a_r9_sel_in_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != '0) |-> (rdy && resp == 2'd0));

  a_r6_err_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && resp != 2'd0) |-> (sel == '0));

  a_r7_align_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && bad_align) |=> (rdy && resp == 2'd1));
endmodule

bind region_decoder region_decoder_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(m_req), .size(m_size), .addr_lo(m_addr[1:0]),
  .rdy(m_rdy), .resp(m_resp), .sel(tgt_sel), .busy(busy)
);

// File: tb/test_region_decoder.sv
module test_region_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [15:0] cfg_base = '0, cfg_size = 16'd1;
  logic [3:0]  cfg_rdly = '0, cfg_wdly = '0;
  logic        cfg_valid = 1'b0, cfg_mc = 1'b0;
  logic        vld_we = 1'b0;
  logic [1:0]  vld_idx = '0;
  logic        vld_val = 1'b0;
  logic        m_req = 1'b0, m_we = 1'b0;
  logic [1:0]  m_size = '0;
  logic [15:0] m_addr = '0;
  logic        m_rdy;
  logic [1:0]  m_resp;
  logic [7:0]  m_rdata;
  logic [31:0] rg_rdata = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
  logic [3:0]  tgt_sel;
  logic [15:0] tgt_off;
  logic        tgt_we;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  region_decoder i_region_decoder (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_base, .cfg_size, .cfg_rdly, .cfg_wdly,
    .cfg_valid, .cfg_mc, .vld_we, .vld_idx, .vld_val, .m_req, .m_we, .m_size,
    .m_addr, .m_rdy, .m_resp, .m_rdata, .rg_rdata, .tgt_sel, .tgt_off, .tgt_we
  );

  logic [1:0]  r_resp;
  logic [3:0]  r_sel;
  logic [15:0] r_off;
  logic [7:0]  r_data;
  logic        r_we;
  int          r_lat;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input int base, input int size, input int rd,
                     input int wd, input bit v, input bit mc);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 2'(idx); cfg_base = 16'(base); cfg_size = 16'(size);
    cfg_rdly = 4'(rd); cfg_wdly = 4'(wd); cfg_valid = v; cfg_mc = mc;
    @(negedge clk);
    cfg_we = 0; cfg_mc = 0;
  endtask

  task automatic setv(input int idx, input bit v);
    @(negedge clk);
    vld_we = 1; vld_idx = 2'(idx); vld_val = v;
    @(negedge clk);
    vld_we = 0;
  endtask

  task automatic acc(input bit we, input int sz, input int a);
    @(negedge clk);
    m_req = 1; m_we = we; m_size = 2'(sz); m_addr = 16'(a);
    r_lat = 0; r_resp = 2'd3; r_sel = '0; r_off = '0; r_data = '0; r_we = 0;
    for (int n = 1; n <= 64; n++) begin
      @(negedge clk);
      if (m_rdy) begin
        r_resp = m_resp; r_sel = tgt_sel; r_off = tgt_off;
        r_data = m_rdata; r_we = tgt_we; r_lat = n;
        break;
      end
    end
    m_req = 0;
    if (r_lat == 0) chk("R9 ready timeout", 0, 1);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    chk("R10 rdy low in reset", int'(m_rdy), 0);
    chk("R10 sel low in reset", int'(tgt_sel), 0);
    rst_n = 1;
    acc(0, 0, 16'h0000);
    chk("R10 no region after reset", int'(r_resp), 2);
    chk("R10 error latency", r_lat, 1);
  endtask

  task automatic t_basic;
    cfg(0, 16'h1000, 16'h100, 2, 3, 1, 0);
    acc(0, 2, 16'h1024);
    chk("R1 resp", int'(r_resp), 0);
    chk("R1 sel", int'(r_sel), 4'b0001);
    chk("R1 offset", int'(r_off), 16'h24);
    chk("R9 read data", int'(r_data), 8'hA0);
    chk("R8 read latency", r_lat, 3);
    acc(1, 2, 16'h10FC);
    chk("R8 write latency", r_lat, 4);
    chk("R9 write strobe", int'(r_we), 1);
    chk("R9 no rdata on write", int'(r_data), 0);
    acc(0, 0, 16'h1100);
    chk("R1 just past window", int'(r_resp), 2);
  endtask

  task automatic t_round;
    cfg(1, 16'h2003, 5, 0, 0, 1, 0);
    acc(0, 0, 16'h2007);
    chk("R2 top byte hit", int'(r_sel), 4'b0010);
    chk("R2 offset", int'(r_off), 7);
    chk("R2 zero wait", r_lat, 1);
    acc(0, 0, 16'h2000);
    chk("R2 base aligned down", int'(r_resp), 0);
    acc(0, 0, 16'h2008);
    chk("R2 beyond rounded size", int'(r_resp), 2);
  endtask

  task automatic t_valid;
    setv(1, 0);
    acc(0, 0, 16'h2004);
    chk("R4 cleared valid misses", int'(r_resp), 2);
    chk("R6 miss selects none", int'(r_sel), 0);
    chk("R6 miss rdata zero", int'(r_data), 0);
    setv(1, 1);
    acc(0, 0, 16'h2004);
    chk("R4 window kept", int'(r_sel), 4'b0010);
    chk("R4 offset kept", int'(r_off), 4);
  endtask

  task automatic t_lowest;
    cfg(2, 16'h1000, 16'h1000, 0, 0, 1, 0);
    acc(0, 2, 16'h1010);
    chk("R5 lowest index wins", int'(r_sel), 4'b0001);
    acc(0, 2, 16'h1800);
    chk("R5 only larger region", int'(r_sel), 4'b0100);
    chk("R5 offset large", int'(r_off), 16'h800);
    chk("R9 data region 2", int'(r_data), 8'hA2);
    setv(0, 0);
    acc(0, 2, 16'h1010);
    chk("R5 fallback after invalidate", int'(r_sel), 4'b0100);
    chk("R5 fallback offset", int'(r_off), 16'h10);
  endtask

  task automatic t_mc;
    cfg(3, 16'h1000, 16'h20, 1, 1, 0, 1);
    acc(0, 2, 16'h1004);
    chk("R3 priority wins overlap", int'(r_sel), 4'b1000);
    chk("R3 priority offset", int'(r_off), 4);
    chk("R3 priority wait", r_lat, 2);
    chk("R9 data region 3", int'(r_data), 8'hA3);
    acc(0, 2, 16'h1040);
    chk("R3 outside priority window", int'(r_sel), 4'b0100);
    cfg(3, 16'h1000, 16'h20, 1, 1, 0, 0);
    acc(0, 2, 16'h1004);
    chk("R3 flag cleared, invalid ignored", int'(r_sel), 4'b0100);
  endtask

  task automatic t_align;
    acc(0, 2, 16'h1002);
    chk("R7 word misaligned", int'(r_resp), 1);
    chk("R7 no select", int'(r_sel), 0);
    chk("R8 align latency", r_lat, 1);
    acc(0, 3, 16'h1001);
    chk("R7 size 3 is word", int'(r_resp), 1);
    acc(1, 1, 16'h1001);
    chk("R7 half misaligned", int'(r_resp), 1);
    acc(0, 1, 16'h1002);
    chk("R7 half aligned", int'(r_resp), 0);
    acc(0, 0, 16'h1003);
    chk("R7 byte any address", int'(r_resp), 0);
    acc(0, 2, 16'h9002);
    chk("R7 align before lookup", int'(r_resp), 1);
  endtask

  initial begin
    t_reset;
    t_basic;
    t_round;
    t_valid;
    t_lowest;
    t_mc;
    t_align;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule